// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block holds an 8-bit up-counting timer and an 8-bit watchdog counter. A single ripple-style prescaler counter serves both of them. One control input decides which of the two counters the prescaler divides for. The other counter then steps on every one of its own source events.

The timer counts one of two things, chosen by a source-select input. The first is a system tick enable. The second is edges on an external pin, taken through a two-flop synchroniser. The edge direction is selectable. When the timer wraps, it sets a sticky flag that software must clear.

Software can load the timer directly. It can also clear the watchdog with a strobe. Each of these writes empties the prescaler when the prescaler currently belongs to the unit being written. When the watchdog counter wraps, the block emits a single-cycle time-out pulse.

Top module: `tmr_wdt_shared_ps`

## Requirements
- R1: After reset the timer count is 0x00, the overflow flag is 0, the watchdog time-out output is 0, and the prescaler is empty.
- R2: A timer write (`tmr_wr` high) loads `tmr_wdata` into the timer on the next clock edge. A write takes priority over an increment in the same cycle.
- R3: With `ps_to_wdt`=0, the timer advances once per 2^(`rate`+1) source events. This gives 1:2 for `rate`=0 up to 1:256 for `rate`=7. Starting from an empty prescaler, N events give floor(N / 2^(`rate`+1)) increments.
- R4: With `ps_to_wdt`=1, the timer advances once per source event, without division.
- R5: With `src_ext`=0 the source event is `sys_tick`=1. With `src_ext`=1 the source event is an edge of `ext_pin`, taken after a two-flop synchroniser. The edge is rising when `edge_fall`=0 and falling when `edge_fall`=1. While `src_ext`=1, `sys_tick` has no effect on the timer.
- R6: An increment from 0xFF to 0x00 sets `tmr_ovf`. The flag stays set until `flag_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R7: A timer write while `ps_to_wdt`=0 clears the prescaler.
- R8: With `ps_to_wdt`=0, the watchdog counter advances on every `wdt_tick`. On the tick that takes it from 0xFF to 0x00, `wdt_timeout` goes high for exactly one cycle, starting at the next clock edge. After that the counter keeps counting from 0x00.
- R9: With `ps_to_wdt`=1, the watchdog advances once per 2^`rate` ticks. This gives 1:1 for `rate`=0 up to 1:128 for `rate`=7.
- R10: `wdt_clr` resets the watchdog counter to 0x00. When `ps_to_wdt`=1 it also clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | Internal instruction-rate count enable |
| ext_pin | input | 1 | External count pin (asynchronous) |
| wdt_tick | input | 1 | Watchdog time-base enable |
| src_ext | input | 1 | Timer source: 0 = `sys_tick`, 1 = external pin edges |
| edge_fall | input | 1 | External edge: 0 = rising, 1 = falling |
| ps_to_wdt | input | 1 | Prescaler owner: 0 = timer, 1 = watchdog |
| rate | input | 3 | Prescaler rate select |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear strobe |
| tmr_count | output | 8 | Timer value |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The bench builds the block with its default widths: an 8-bit timer, an 8-bit prescaler and an 8-bit watchdog. At these widths both wraps can be reached in full within the cycle budget, including a watchdog time-out behind a 1:2 prescale of 512 ticks. Rate codes 0, 2 and 7 cover the smallest ratio, a middle ratio and the full 1:256 tap. The prescaler-clearing cases are chosen so that a missing clear would move an increment or a time-out by exactly one event.

// File: rtl/tmr_wdt_shared_ps.sv
module tmr_wdt_shared_ps #(
  parameter int TMR_W = 8,
  parameter int PS_W  = 8,
  parameter int WDT_W = 8,
  parameter int SEL_W = $clog2(PS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_tick,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             ps_to_wdt,
  input  logic [SEL_W-1:0] rate,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             flag_clr,
  input  logic             wdt_clr,
  output logic [TMR_W-1:0] tmr_count,
  output logic             tmr_ovf,
  output logic             wdt_timeout
);

  localparam logic [PS_W-1:0]  PS_ONES  = {PS_W{1'b1}};
  localparam logic [TMR_W-1:0] TMR_TOP  = {TMR_W{1'b1}};
  localparam logic [WDT_W-1:0] WDT_TOP  = {WDT_W{1'b1}};

  logic [2:0]       pin_q;
  logic [PS_W-1:0]  ps_cnt;
  logic [WDT_W-1:0] wdt_cnt;

  logic [SEL_W:0]   tshift;
  logic [PS_W-1:0]  tmask, wmask;
  logic             ext_edge, tmr_src, ps_in, ps_clr;
  logic             tdiv_hit, wdiv_hit, tmr_inc, wdt_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], ext_pin};

  assign ext_edge = edge_fall ? (!pin_q[1] && pin_q[2]) : (pin_q[1] && !pin_q[2]);
  assign tmr_src  = src_ext ? ext_edge : sys_tick;
  assign ps_in    = ps_to_wdt ? wdt_tick : tmr_src;
  assign ps_clr   = ps_to_wdt ? wdt_clr : tmr_wr;

  assign tshift   = {1'b0, rate} + 1'b1;
  assign tmask    = ~(PS_ONES << tshift);
  assign wmask    = ~(PS_ONES << rate);
  assign tdiv_hit = &(ps_cnt | ~tmask);
  assign wdiv_hit = &(ps_cnt | ~wmask);

  assign tmr_inc  = ps_to_wdt ? tmr_src : (ps_in && tdiv_hit);
  assign wdt_inc  = ps_to_wdt ? (wdt_tick && wdiv_hit) : wdt_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ps_cnt <= '0;
    else if (ps_clr) ps_cnt <= '0;
    else if (ps_in)  ps_cnt <= ps_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tmr_count <= '0;
    else if (tmr_wr)  tmr_count <= tmr_wdata;
    else if (tmr_inc) tmr_count <= tmr_count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                      tmr_ovf <= 1'b0;
    else if (tmr_inc && !tmr_wr && tmr_count == TMR_TOP) tmr_ovf <= 1'b1;
    else if (flag_clr)                               tmr_ovf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wdt_cnt     <= '0;
      wdt_timeout <= 1'b0;
    end else begin
      wdt_timeout <= !wdt_clr && wdt_inc && wdt_cnt == WDT_TOP;
      if (wdt_clr)      wdt_cnt <= '0;
      else if (wdt_inc) wdt_cnt <= wdt_cnt + 1'b1;
    end

  assert_ovf_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_count) == TMR_TOP && tmr_count == '0 && !$past(tmr_wr)) |-> tmr_ovf);

  assert_tmr_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tmr_wr) |-> (tmr_count == $past(tmr_count) ||
                        tmr_count == TMR_W'($past(tmr_count) + 1'b1)));

  assert_write_clears_ps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_wr) && !$past(ps_to_wdt)) |-> ps_cnt == '0);

  assert_wdt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wdt_clr) |-> (wdt_cnt == '0 && (!$past(ps_to_wdt) || ps_cnt == '0)));

  assert_timeout_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  assert_timeout_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |-> wdt_cnt == '0);

endmodule

// File: tb/tb_tmr_wdt_shared_ps.sv
module tb_tmr_wdt_shared_ps;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_tick = 0, ext_pin = 0, wdt_tick = 0, src_ext = 0, edge_fall = 0;
  logic ps_to_wdt = 0, tmr_wr = 0, flag_clr = 0, wdt_clr = 0;
  logic [2:0] rate = 0;
  logic [7:0] tmr_wdata = 0;
  logic [7:0] tmr_count;
  logic tmr_ovf, wdt_timeout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_wdt_shared_ps dut (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .src_ext(src_ext), .edge_fall(edge_fall),
    .ps_to_wdt(ps_to_wdt), .rate(rate), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .flag_clr(flag_clr), .wdt_clr(wdt_clr), .tmr_count(tmr_count),
    .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_tmr(logic [7:0] v);
    tmr_wdata = v; tmr_wr = 1;
    @(negedge clk); tmr_wr = 0;
  endtask

  task automatic ticks(int n);
    sys_tick = 1;
    repeat (n) @(negedge clk);
    sys_tick = 0;
  endtask

  task automatic wdt_clear();
    wdt_clr = 1; @(negedge clk); wdt_clr = 0;
  endtask

  task automatic t_reset;
    check("R1 count", tmr_count, 0);
    check("R1 ovf", tmr_ovf, 0);
    check("R1 timeout", wdt_timeout, 0);
  endtask

  task automatic t_rates;
    ps_to_wdt = 0; src_ext = 0;
    rate = 0; write_tmr(0); ticks(300); check("R3 rate0", tmr_count, 150);
    rate = 2; write_tmr(0); ticks(100); check("R3 rate2", tmr_count, 12);
    rate = 7; write_tmr(0); ticks(600); check("R3 rate7", tmr_count, 2);
    write_tmr(8'h5A); check("R2 load", tmr_count, 8'h5A);
  endtask

  task automatic t_nodiv;
    ps_to_wdt = 1; rate = 7; write_tmr(0); ticks(37);
    check("R4 undivided", tmr_count, 37);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1; repeat (3) @(negedge clk);
      ext_pin = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ext;
    ps_to_wdt = 1; src_ext = 1; edge_fall = 0; write_tmr(0);
    sys_tick = 1; pulses(5); sys_tick = 0;
    check("R5 rising edges, sys_tick ignored", tmr_count, 5);
    edge_fall = 1; write_tmr(0);
    ext_pin = 1; repeat (4) @(negedge clk);
    check("R5 rising edge not counted when falling selected", tmr_count, 0);
    ext_pin = 0; repeat (4) @(negedge clk);
    pulses(2);
    check("R5 falling edges", tmr_count, 3);
    src_ext = 0; edge_fall = 0;
  endtask

  task automatic t_ovf;
    ps_to_wdt = 1; src_ext = 0; flag_clr = 1; @(negedge clk); flag_clr = 0;
    write_tmr(8'hFE); ticks(1);
    check("R6 at FF", tmr_count, 8'hFF); check("R6 no flag yet", tmr_ovf, 0);
    ticks(1);
    check("R6 wrapped", tmr_count, 0); check("R6 flag set", tmr_ovf, 1);
    ticks(3); check("R6 flag sticky", tmr_ovf, 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R6 flag cleared", tmr_ovf, 0);
  endtask

  task automatic t_psclr;
    ps_to_wdt = 0; rate = 2; write_tmr(0); ticks(5);
    check("R7 before rewrite", tmr_count, 0);
    write_tmr(0); ticks(7);
    check("R7 prescaler emptied by write", tmr_count, 0);
    ticks(1); check("R7 eighth event", tmr_count, 1);
  endtask

  task automatic wdt_run(int n, string req);
    int seen = 0, at = 0;
    wdt_tick = 1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wdt_timeout) begin seen++; at = i; end
    end
    wdt_tick = 0;
    @(negedge clk);
    check({req, " single pulse"}, seen, 1);
    check({req, " pulse position"}, at, n);
    check({req, " pulse ended"}, wdt_timeout, 0);
  endtask

  task automatic t_wdt;
    ps_to_wdt = 0; rate = 5; wdt_clear();
    wdt_run(256, "R8");
    ps_to_wdt = 1; rate = 1; wdt_clear();
    wdt_tick = 1; @(negedge clk); wdt_tick = 0;
    wdt_clear();
    wdt_run(512, "R9 R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset; t_rates; t_nodiv; t_ext; t_ovf; t_psclr; t_wdt;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule